// File: doc/BRIEF.md
# Virtual Processor Run/Stop Controller

This block holds a running bitmap for a cluster of virtual processors and lets software start or halt any subset of them through memory-mapped registers. A write to the start register turns on every selected processor that is not yet running and gives each of those a single-clock wake pulse. A write to the halt register turns off every selected processor that is running. Each processor also has a level output that is high while it is halted. A third register reads back the bitmap.

The register set can be reached through two address windows that behave the same: a local-cluster window and a window used to reach another core. Leaving reset, the block starts a configured subset of processors on its own, and each of them gets a wake pulse just as if software had written that subset to the start register. The data bus is 64 bits wide. A write takes effect in the cycle it is strobed. Read data arrives one cycle after the read strobe.

Top module: `vp_runctl`

## Requirements
- R1: Only bits 0 to NUM_VP-1 of a start or halt write have any effect. Running bits at or above NUM_VP never get set, and read data returns zero in those bit positions.
- R2: A start write sets the running bit of each selected processor. A one-clock wake pulse is raised in the cycle after the write, and only for processors that were not already running.
- R3: A halt write clears the running bit of each selected processor that is running. In the cycle after the write, its halt output is high, and any wake that would have been raised in that same cycle is withdrawn.
- R4: For every processor, the halt output is the inverse of its running bit at all times.
- R5: A read strobe to the running register returns the bitmap as it stood before that clock edge, zero-extended to 64 bits, on rdata in the following cycle. In a cycle that follows no mapped read, rdata is zero.
- R6: The two windows start at byte addresses 0x2000 and 0x4000. Inside each window the start register is at offset 0x20, the halt register at 0x28 and the running register at 0x30. Both windows act the same.
- R7: While in reset, the bitmap is zero, wake is low and every halt output is high. At the first clock edge after reset is released, the bitmap becomes START_RUNNING masked to NUM_VP, and those processors get a one-clock wake pulse.
- R8: A write to any address other than a start or halt register changes nothing and gives no wake. A read of any address other than a running register returns zero.
- R9: A START_RUNNING value with a bit set at or above NUM_VP is an illegal configuration, and an assertion flags it at elaboration.
- R10: Writing the start register again for a processor that is already running raises no further wake pulse for it and leaves it running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 16 | Byte address of the access |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid the cycle after rd_en |
| wake | output | NUM_VP | One-clock wake pulse per processor |
| halt | output | NUM_VP | High while the processor is not running |

## Verification
The bench writes the start register again for processors that are already running. A design that sets wake from the write data alone, instead of from the bits that actually change, would pulse those processors a second time. It sends write data with bits set above NUM_VP, and it sends accesses to unmapped or neighbouring addresses. These cases expose a missing mask or a decoder that matches too loosely, either of which would start phantom processors or return bitmap data where zero is due. It checks the wake pulse for the reset start mask in the first cycle after reset, and it drives both windows in random order. This catches a boot subset that is lost, or a window that was left out of the decoder.

// File: rtl/vpctl_pkg.sv
package vpctl_pkg;

  localparam int unsigned DATA_W  = 64;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned NUM_WIN = 2;

  localparam logic [ADDR_W-1:0] OFS_START   = 16'h0020;
  localparam logic [ADDR_W-1:0] OFS_HALT    = 16'h0028;
  localparam logic [ADDR_W-1:0] OFS_RUNNING = 16'h0030;

  // Base address of an aliased window; index 0 is local, 1 is core-other
  function automatic logic [ADDR_W-1:0] win_base(input int unsigned w);
    return (w == 0) ? 16'h2000 : 16'h4000;
  endfunction

  // Bits 0..n-1 set, built without a shift that overflows at n = 64
  function automatic logic [DATA_W-1:0] vp_mask(input int unsigned n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // Processors that a start request turns on
  function automatic logic [DATA_W-1:0] newly_started(input logic [DATA_W-1:0] cur,
                                                     input logic [DATA_W-1:0] req);
    return req & ~cur;
  endfunction

  // Processors that a halt request turns off
  function automatic logic [DATA_W-1:0] newly_stopped(input logic [DATA_W-1:0] cur,
                                                     input logic [DATA_W-1:0] req);
    return req & cur;
  endfunction

endpackage

// File: rtl/vpctl_decode.sv
module vpctl_decode
  import vpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              start_hit,
  output logic              halt_hit,
  output logic              read_hit
);

  logic [NUM_WIN-1:0] m_start;
  logic [NUM_WIN-1:0] m_halt;
  logic [NUM_WIN-1:0] m_read;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign m_start[w] = (addr == win_base(w) + OFS_START);
    assign m_halt[w]  = (addr == win_base(w) + OFS_HALT);
    assign m_read[w]  = (addr == win_base(w) + OFS_RUNNING);
  end

  assign start_hit = wr_en && (|m_start);
  assign halt_hit  = wr_en && (|m_halt);
  assign read_hit  = rd_en && (|m_read);

  // R6: one address never decodes to two registers
  p_single_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|m_start, |m_halt, |m_read}))
    else $error("p_single_reg_r6");

  // R8: no strobe, no register access
  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |-> !(start_hit || halt_hit || read_hit))
    else $error("p_no_strobe_r8");

endmodule

// File: rtl/vpctl_bitmap.sv
module vpctl_bitmap
  import vpctl_pkg::*;
#(
  parameter int unsigned       NUM_VP        = 1,
  parameter logic [DATA_W-1:0] START_RUNNING = 64'h1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic              halt_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] running_q,
  output logic [DATA_W-1:0] wake_q
);

  localparam logic [DATA_W-1:0] VALID     = vp_mask(NUM_VP);
  localparam logic [DATA_W-1:0] BOOT_MASK = START_RUNNING & VALID;

  logic              boot_pend_q;
  logic [DATA_W-1:0] start_req;
  logic [DATA_W-1:0] halt_req;
  logic [DATA_W-1:0] started;
  logic [DATA_W-1:0] stopped;
  logic [DATA_W-1:0] running_d;
  logic [DATA_W-1:0] wake_d;

  // Start is applied first, then halt (bus order within a cycle)
  always_comb begin
    start_req = (boot_pend_q ? BOOT_MASK : '0) | (start_hit ? (wdata & VALID) : '0);
    halt_req  = halt_hit ? (wdata & VALID) : '0;
    started   = newly_started(running_q, start_req);
    stopped   = newly_stopped(running_q | started, halt_req);
    running_d = (running_q | started) & ~stopped;
    wake_d    = started & ~stopped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend_q <= 1'b1;
      running_q   <= '0;
      wake_q      <= '0;
    end else begin
      boot_pend_q <= 1'b0;
      running_q   <= running_d;
      wake_q      <= wake_d;
    end
  end

  // R9: start subset must fit in the configured processor count
  initial begin
    p_start_legal_r9: assert ((START_RUNNING & ~VALID) == '0)
      else $error("p_start_legal_r9: START_RUNNING exceeds NUM_VP");
  end

  // R1: nothing above NUM_VP is ever running or woken
  p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((running_q | wake_q) & ~VALID) == '0)
    else $error("p_mask_r1");

  // R2: wake only for processors that were stopped one cycle earlier
  p_wake_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q & $past(running_q)) == '0)
    else $error("p_wake_new_r2");

  // R2: a start write leaves every selected processor running
  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && !halt_hit) |=> ((running_q & $past(wdata) & VALID) == ($past(wdata) & VALID)))
    else $error("p_start_sets_r2");

  // R3: a halt write leaves every selected processor stopped and unwoken
  p_halt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_hit |=> (((running_q | wake_q) & $past(wdata) & VALID) == '0))
    else $error("p_halt_clears_r3");

  // R7: the boot subset is running after the first edge out of reset
  p_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(boot_pend_q) && !$past(halt_hit)) |-> ((wake_q & BOOT_MASK) == BOOT_MASK))
    else $error("p_boot_r7");

  // R8: with no register write the bitmap holds and no wake is raised
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_hit && !halt_hit && !boot_pend_q) |=> ($stable(running_q) && wake_q == '0))
    else $error("p_idle_r8");

  // R10: a woken processor is always one that is running
  p_wake_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q & ~running_q) == '0)
    else $error("p_wake_running_r10");

endmodule

// File: rtl/vpctl_rdpath.sv
module vpctl_rdpath
  import vpctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read_hit,
  input  logic [DATA_W-1:0] running_q,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= read_hit ? running_q : '0;
  end

  // R5: one cycle of read latency, returning the bitmap before the edge
  p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    read_hit |=> (rdata == $past(running_q)))
    else $error("p_rd_latency_r5");

  // R8: no mapped read, zero data
  p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !read_hit |=> (rdata == '0))
    else $error("p_rd_zero_r8");

endmodule

// File: rtl/vp_runctl.sv
module vp_runctl
  import vpctl_pkg::*;
#(
  parameter int unsigned       NUM_VP        = 1,
  parameter logic [DATA_W-1:0] START_RUNNING = 64'h1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_VP-1:0] wake,
  output logic [NUM_VP-1:0] halt
);

  logic              start_hit;
  logic              halt_hit;
  logic              read_hit;
  logic [DATA_W-1:0] running_q;
  logic [DATA_W-1:0] wake_q;

  vpctl_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .start_hit (start_hit),
    .halt_hit  (halt_hit),
    .read_hit  (read_hit)
  );

  vpctl_bitmap #(
    .NUM_VP        (NUM_VP),
    .START_RUNNING (START_RUNNING)
  ) u_bitmap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .halt_hit  (halt_hit),
    .wdata     (wdata),
    .running_q (running_q),
    .wake_q    (wake_q)
  );

  vpctl_rdpath u_rdpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .read_hit  (read_hit),
    .running_q (running_q),
    .rdata     (rdata)
  );

  assign wake = wake_q[NUM_VP-1:0];
  assign halt = ~running_q[NUM_VP-1:0];

  // R4: halt and wake never both high for one processor
  p_halt_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt & wake) == '0)
    else $error("p_halt_wake_r4");

endmodule

// File: tb/test_vp_runctl.sv
module test_vp_runctl;

  localparam int unsigned NV = 8;
  localparam logic [63:0] ST = 64'h05;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [NV-1:0] wake;
  logic [NV-1:0] halt;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] exp_run = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  vp_runctl #(.NUM_VP(NV), .START_RUNNING(ST)) i_vp_runctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wake(wake), .halt(halt)
  );

  function automatic logic [63:0] m_valid();
    logic [63:0] v = '0;
    for (int i = 0; i < int'(NV); i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic bit is_mapped(input logic [15:0] a);
    return a == 16'h2020 || a == 16'h2028 || a == 16'h2030 ||
           a == 16'h4020 || a == 16'h4028 || a == 16'h4030;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_halt(input string tag);
    chk(halt == ~exp_run[NV-1:0], tag, 64'(halt), 64'(~exp_run[NV-1:0]));
  endtask

  // Start write: pulse expected for the newly started ones only
  task automatic wr_start(input logic [15:0] a, input logic [63:0] d, input string tag);
    logic [63:0] ew;
    ew = (d & m_valid()) & ~exp_run;
    exp_run = exp_run | (d & m_valid());
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    chk(wake == ew[NV-1:0], tag, 64'(wake), ew);
    check_halt({tag, " R4"});
    @(negedge clk);
    chk(wake == '0, {tag, " pulse end R2"}, 64'(wake), 64'h0);
  endtask

  task automatic wr_halt(input logic [15:0] a, input logic [63:0] d, input string tag);
    exp_run = exp_run & ~(d & m_valid());
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    chk(wake == '0, {tag, " no wake R3"}, 64'(wake), 64'h0);
    check_halt(tag);
  endtask

  task automatic wr_other(input logic [15:0] a, input logic [63:0] d, input string tag);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    chk(wake == '0, {tag, " wake"}, 64'(wake), 64'h0);
    check_halt(tag);
  endtask

  task automatic rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
    @(negedge clk);
    chk(rdata == '0, {tag, " idle R5"}, rdata, 64'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] base;
    logic [15:0] a;
    logic [63:0] d;
    void'($urandom(32'd20240611));

    // R7 reset state
    repeat (3) @(negedge clk);
    chk(wake == '0, "R7 reset wake", 64'(wake), 64'h0);
    chk(halt == '1, "R7 reset halt", 64'(halt), 64'hff);
    chk(rdata == '0, "R7 reset rdata", rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wake == ST[NV-1:0], "R7 boot wake", 64'(wake), ST);
    exp_run = ST;
    check_halt("R7 boot halt");
    @(negedge clk);
    chk(wake == '0, "R7 boot pulse end", 64'(wake), 64'h0);

    // R5/R6 read both windows
    rd(16'h2030, exp_run, "R5 R6 read local");
    rd(16'h4030, exp_run, "R6 read core-other");

    // R10 rewrite running processors
    wr_start(16'h2020, 64'h05, "R10 restart running");
    wr_start(16'h4020, 64'h05, "R10 restart alias");

    // R2 partial overlap
    wr_start(16'h2020, 64'h0f, "R2 overlap start");
    // R1 upper bits ignored
    wr_start(16'h4020, 64'hffff_ff00_0000_0010, "R1 upper bits");
    rd(16'h2030, exp_run, "R1 read masked");

    // R3 halt, including a halt of already stopped ones
    wr_halt(16'h4028, 64'hffff_ffff_ffff_ff03, "R3 halt");
    wr_halt(16'h2028, 64'h03, "R3 halt stopped");
    rd(16'h4030, exp_run, "R3 read after halt");

    // R8 neighbouring and unmapped addresses
    wr_other(16'h2021, 64'hff, "R8 misaligned write");
    wr_other(16'h2030, 64'hff, "R8 write to running reg");
    wr_other(16'h3020, 64'hff, "R8 unmapped window");
    rd(16'h2020, 64'h0, "R8 read start reg");
    rd(16'h0030, 64'h0, "R8 read unmapped");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      base = ($urandom_range(0, 1) == 0) ? 16'h2000 : 16'h4000;
      d = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) d = d & 64'hff;
      case ($urandom_range(0, 4))
        0: wr_start(base + 16'h20, d, "R2 random start");
        1: wr_halt(base + 16'h28, d, "R3 random halt");
        2: rd(base + 16'h30, exp_run, "R5 random read");
        3: begin
          a = 16'($urandom());
          if (is_mapped(a)) a = a ^ 16'h0001;
          wr_other(a, d, "R8 random unmapped write");
        end
        default: begin
          a = 16'($urandom());
          if (is_mapped(a)) a = a ^ 16'h0004;
          rd(a, 64'h0, "R8 random unmapped read");
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule